// File: doc/BRIEF.md
# Virtual-Address to Mesh-Node Translator

This block turns the virtual word address of an outgoing message into the X, Y and Z coordinates of the 3-D mesh node that owns that address. It holds a small, fully associative set of mapping entries that system software writes. Each entry covers a page-group whose size is a power of two pages. The entry spreads that page-group over a rectangle of nodes whose side lengths are also powers of two. A page is 1024 words, so the virtual page number is the word address with its ten low bits dropped.

Inside an entry's page-group, the page offset is divided by the pages-per-node count, which is stored as a log2. The quotient is reduced modulo the node count of the region. The result is split into X (low bits), Y (middle bits) and Z (high bits), using each axis's log2 extent as the bit count, and then added to the entry's starting node. A pages-per-node value of zero gives cyclic interleave, where consecutive pages go to consecutive nodes. Larger values give block interleave, where runs of pages stay on one node.

A lookup is answered one cycle later by a three-state result register. IDLE means no lookup was made in the previous cycle. HIT means the lookup matched an entry and carries valid coordinates. MISS means no valid entry matched; this is the fault indication. From every state, the next state is IDLE when no lookup is presented, HIT when a lookup matches, and MISS when a lookup does not match.

Top module: `vnt_xlate`

## Requirements
- R1: While reset is asserted and after it is released, all entries are invalid, and `res_valid`, `res_hit`, `res_miss` and the coordinates read 0 until the first lookup.
- R2: A lookup presented with `lk_valid` high produces `res_valid` high on the next cycle. `res_valid` is low in every cycle that follows a cycle without a lookup.
- R3: The page number is `lk_vaddr >> 10`. A valid entry matches when its tag agrees with the page number on every bit at or above bit position `glen`, where `glen` is the entry's log2 page-group length.
- R4: The node index is floor(page offset within the group / 2^ppn), taken modulo 2^(ex+ey+ez). Here `ppn` is the log2 pages-per-node value, so `ppn`=0 gives cyclic interleave and `ppn`>0 gives block interleave.
- R5: X is the start X plus the low `ex` bits of the index. Y is the start Y plus the next `ey` bits. Z is the start Z plus the next `ez` bits. Each sum wraps modulo 2^6.
- R6: A lookup that matches no valid entry gives `res_miss`=1, `res_hit`=0 and all coordinates 0. `res_hit` and `res_miss` are never high together.
- R7: Fills go to entries 0, 1, ... 7 in round-robin order and wrap to 0. The ninth fill after reset replaces entry 0.
- R8: `inval_all` invalidates every entry and returns the fill pointer to entry 0. It overrides a fill in the same cycle, so that fill is ignored.
- R9: When several valid entries match, the entry with the lowest index supplies the coordinates.
- R10: A lookup made in the same cycle as a fill sees the table as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write the fill fields into the entry at the round-robin pointer |
| inval_all | input | 1 | Invalidate all entries and reset the pointer |
| fill_vpage | input | 22 | Virtual page tag of the new entry |
| fill_sx | input | 6 | Starting node X |
| fill_sy | input | 6 | Starting node Y |
| fill_sz | input | 6 | Starting node Z |
| fill_ex | input | 3 | log2 of the region size along X |
| fill_ey | input | 3 | log2 of the region size along Y |
| fill_ez | input | 3 | log2 of the region size along Z |
| fill_glen | input | 5 | log2 of the page-group length in pages |
| fill_ppn | input | 4 | log2 of the consecutive pages placed on each node |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual word address to translate |
| res_valid | output | 1 | A result for last cycle's lookup is present |
| res_hit | output | 1 | The lookup matched an entry |
| res_miss | output | 1 | The lookup matched no entry (fault) |
| res_x | output | 6 | Destination node X |
| res_y | output | 6 | Destination node Y |
| res_z | output | 6 | Destination node Z |

## Verification
The checker tests the following on every cycle:
- the one-cycle link between a lookup and `res_valid`;
- the exclusive hit and miss flags;
- zeroed coordinates on a miss;
- a miss on the first lookup after a global invalidate.

Only the bench's scenarios can show the following:
- the arithmetic of block and cyclic interleave;
- the X/Y/Z bit split with wrap-around;
- tag matching above the group size;
- lowest-index priority among overlapping entries;
- round-robin replacement;
- the ordering of a fill against a lookup in the same cycle.

The bench's reference model computes these with integer division and modulo, and it is compared against the outputs on every clock.

// File: rtl/vnt_pkg.sv
`timescale 1ns/1ps
package vnt_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned PG_SHIFT = 10;
    localparam int unsigned VPN_W    = VA_W - PG_SHIFT;
    localparam int unsigned COORD_W  = 6;
    localparam int unsigned EXT_W    = 3;
    localparam int unsigned GLEN_W   = 5;
    localparam int unsigned PPN_W    = 4;

    typedef struct packed {
        logic [VPN_W-1:0]   vpage;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic [COORD_W-1:0] sz;
        logic [EXT_W-1:0]   ex;
        logic [EXT_W-1:0]   ey;
        logic [EXT_W-1:0]   ez;
        logic [GLEN_W-1:0]  glen;
        logic [PPN_W-1:0]   ppn;
    } vnt_entry_t;

    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } res_state_e;

    // Mask with the n low bits set; saturates to all ones.
    function automatic logic [VPN_W-1:0] low_mask(input int unsigned n);
        if (n >= VPN_W) return '1;
        return (VPN_W'(1) << n) - VPN_W'(1);
    endfunction
endpackage

// File: rtl/vnt_entry_store.sv
`timescale 1ns/1ps
module vnt_entry_store
    import vnt_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic               inval_all,
    input  vnt_entry_t         fill_ent,
    output vnt_entry_t         ent_q [NUM_ENT],
    output logic [NUM_ENT-1:0] vld_q
);
    logic [IDX_W-1:0] wr_ptr;

    // R7: round-robin fill pointer; R8: invalidate resets it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (inval_all) begin
            wr_ptr <= '0;
        end else if (fill_en) begin
            wr_ptr <= (wr_ptr == IDX_W'(NUM_ENT - 1)) ? '0 : wr_ptr + IDX_W'(1);
        end
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                ent_q[i] <= '0;
            end else if (inval_all) begin
                vld_q[i] <= 1'b0;
            end else if (fill_en && (wr_ptr == IDX_W'(i))) begin
                vld_q[i] <= 1'b1;
                ent_q[i] <= fill_ent;
            end
        end
    end
endmodule

// File: rtl/vnt_match.sv
`timescale 1ns/1ps
module vnt_match
    import vnt_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [VPN_W-1:0]  tag_a  [NUM_ENT],
    input  logic [GLEN_W-1:0] glen_a [NUM_ENT],
    input  logic [NUM_ENT-1:0] vld,
    output logic              any_hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [NUM_ENT-1:0] match;

    // R3: compare only the bits above the page-group size
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        logic [VPN_W-1:0] hi_mask;
        assign hi_mask  = ~low_mask(int'(glen_a[i]));
        assign match[i] = vld[i] && (((tag_a[i] ^ vpn) & hi_mask) == '0);
    end

    // R9: lowest index wins
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_hit = |match;
endmodule

// File: rtl/vnt_coord_calc.sv
`timescale 1ns/1ps
module vnt_coord_calc
    import vnt_pkg::*;
(
    input  logic [VPN_W-1:0]   vpn,
    input  logic [GLEN_W-1:0]  glen,
    input  logic [PPN_W-1:0]   ppn,
    input  logic [EXT_W-1:0]   ex,
    input  logic [EXT_W-1:0]   ey,
    input  logic [EXT_W-1:0]   ez,
    input  logic [COORD_W-1:0] sx,
    input  logic [COORD_W-1:0] sy,
    input  logic [COORD_W-1:0] sz,
    output logic [COORD_W-1:0] nx,
    output logic [COORD_W-1:0] ny,
    output logic [COORD_W-1:0] nz
);
    logic [VPN_W-1:0] offs, slot, idx, dx, dy, dz;
    int unsigned      n_xy, n_all;

    always_comb begin
        n_xy  = int'(ex) + int'(ey);
        n_all = n_xy + int'(ez);
        offs  = vpn & low_mask(int'(glen));                    // R4 group offset
        slot  = offs >> ppn;                                    // R4 interleave
        idx   = slot & low_mask(n_all);                         // R4 region wrap
        dx    = idx & low_mask(int'(ex));                       // R5 X low bits
        dy    = (idx >> ex) & low_mask(int'(ey));               // R5 Y middle
        dz    = (idx >> n_xy) & low_mask(int'(ez));             // R5 Z high
        nx    = sx + dx[COORD_W-1:0];
        ny    = sy + dy[COORD_W-1:0];
        nz    = sz + dz[COORD_W-1:0];
    end
endmodule

// File: rtl/vnt_xlate.sv
`timescale 1ns/1ps
module vnt_xlate
    import vnt_pkg::*;
#(
    parameter int NUM_ENT = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic               inval_all,
    input  logic [VPN_W-1:0]   fill_vpage,
    input  logic [COORD_W-1:0] fill_sx,
    input  logic [COORD_W-1:0] fill_sy,
    input  logic [COORD_W-1:0] fill_sz,
    input  logic [EXT_W-1:0]   fill_ex,
    input  logic [EXT_W-1:0]   fill_ey,
    input  logic [EXT_W-1:0]   fill_ez,
    input  logic [GLEN_W-1:0]  fill_glen,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_miss,
    output logic [COORD_W-1:0] res_x,
    output logic [COORD_W-1:0] res_y,
    output logic [COORD_W-1:0] res_z
);
    vnt_entry_t         fill_ent;
    vnt_entry_t         ent_q [NUM_ENT];
    logic [NUM_ENT-1:0] vld_q;
    logic [VPN_W-1:0]   tag_a  [NUM_ENT];
    logic [GLEN_W-1:0]  glen_a [NUM_ENT];
    logic [VPN_W-1:0]   vpn;
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;
    vnt_entry_t         pick;
    logic [COORD_W-1:0] cx, cy, cz;
    logic [COORD_W-1:0] x_q, y_q, z_q;
    res_state_e         state_q, state_d;
    logic               unused_page_offset;

    assign fill_ent = '{vpage: fill_vpage, sx: fill_sx, sy: fill_sy, sz: fill_sz,
                        ex: fill_ex, ey: fill_ey, ez: fill_ez,
                        glen: fill_glen, ppn: fill_ppn};

    assign vpn                = lk_vaddr[VA_W-1:PG_SHIFT];     // R3
    assign unused_page_offset = ^lk_vaddr[PG_SHIFT-1:0];

    vnt_entry_store #(.NUM_ENT(NUM_ENT)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .inval_all (inval_all),
        .fill_ent  (fill_ent),
        .ent_q     (ent_q),
        .vld_q     (vld_q)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_fld
        assign tag_a[i]  = ent_q[i].vpage;
        assign glen_a[i] = ent_q[i].glen;
    end

    vnt_match #(.NUM_ENT(NUM_ENT)) u_match (
        .vpn     (vpn),
        .tag_a   (tag_a),
        .glen_a  (glen_a),
        .vld     (vld_q),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    assign pick = ent_q[hit_idx];

    vnt_coord_calc u_calc (
        .vpn  (vpn),
        .glen (pick.glen),
        .ppn  (pick.ppn),
        .ex   (pick.ex),
        .ey   (pick.ey),
        .ez   (pick.ez),
        .sx   (pick.sx),
        .sy   (pick.sy),
        .sz   (pick.sz),
        .nx   (cx),
        .ny   (cy),
        .nz   (cz)
    );

    // Next-state logic: every state leaves by the same three arcs
    always_comb begin
        state_d = RES_IDLE;
        unique case (state_q)
            RES_IDLE, RES_HIT, RES_MISS: begin
                if (!lk_valid)    state_d = RES_IDLE;
                else if (any_hit) state_d = RES_HIT;
                else              state_d = RES_MISS;
            end
            default: state_d = RES_IDLE;
        endcase
    end

    // State register and registered coordinates (R2 one-cycle latency)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            x_q     <= '0;
            y_q     <= '0;
            z_q     <= '0;
        end else begin
            state_q <= state_d;
            if (lk_valid && any_hit) begin
                x_q <= cx;
                y_q <= cy;
                z_q <= cz;
            end else begin
                x_q <= '0;                                      // R6
                y_q <= '0;
                z_q <= '0;
            end
        end
    end

    // Output decode
    always_comb begin
        res_valid = (state_q != RES_IDLE);
        res_hit   = (state_q == RES_HIT);
        res_miss  = (state_q == RES_MISS);
        res_x     = x_q;
        res_y     = y_q;
        res_z     = z_q;
    end
endmodule

// File: rtl/vnt_xlate_chk.sv
`timescale 1ns/1ps
module vnt_xlate_chk
    import vnt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               inval_all,
    input logic               res_valid,
    input logic               res_hit,
    input logic               res_miss,
    input logic [COORD_W-1:0] res_x,
    input logic [COORD_W-1:0] res_y,
    input logic [COORD_W-1:0] res_z
);
    assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_flag_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));

    assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_miss));

    assert_miss_zero_coord_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_x == '0 && res_y == '0 && res_z == '0));

    assert_inval_then_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all ##1 lk_valid) |=> res_miss);
endmodule

bind vnt_xlate vnt_xlate_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .inval_all (inval_all),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_x     (res_x),
    .res_y     (res_y),
    .res_z     (res_z)
);

// File: tb/vnt_xlate_tb_top.sv
`timescale 1ns/1ps
module vnt_xlate_tb_top;
    import vnt_pkg::*;
    localparam int NE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_en = 1'b0, inval_all = 1'b0, lk_valid = 1'b0;
    logic [VPN_W-1:0]   fill_vpage = '0;
    logic [COORD_W-1:0] fill_sx = '0, fill_sy = '0, fill_sz = '0;
    logic [EXT_W-1:0]   fill_ex = '0, fill_ey = '0, fill_ez = '0;
    logic [GLEN_W-1:0]  fill_glen = '0;
    logic [PPN_W-1:0]   fill_ppn = '0;
    logic [VA_W-1:0]    lk_vaddr = '0;
    logic res_valid, res_hit, res_miss;
    logic [COORD_W-1:0] res_x, res_y, res_z;

    always #2.5 clk = ~clk;

    vnt_xlate #(.NUM_ENT(NE)) dut_i (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .inval_all(inval_all),
        .fill_vpage(fill_vpage), .fill_sx(fill_sx), .fill_sy(fill_sy), .fill_sz(fill_sz),
        .fill_ex(fill_ex), .fill_ey(fill_ey), .fill_ez(fill_ez),
        .fill_glen(fill_glen), .fill_ppn(fill_ppn),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_x(res_x), .res_y(res_y), .res_z(res_z)
    );

    // Behavioural reference model
    longint m_tag [NE];
    int     m_sx [NE], m_sy [NE], m_sz [NE], m_ex [NE], m_ey [NE], m_ez [NE];
    int     m_gl [NE], m_pp [NE];
    bit     m_vld [NE];
    int     m_ptr = 0;
    bit     e_valid = 0, e_hit = 0, e_miss = 0;
    int     e_x = 0, e_y = 0, e_z = 0;
    bit     armed = 0;
    int     n_cmp = 0, n_bad = 0, cyc = 0;
    string  cur_req = "R1";

    always @(posedge clk) begin
        longint vpn, off, idx;
        int     found;
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) m_vld[i] = 0;
            m_ptr = 0;
            e_valid = 0; e_hit = 0; e_miss = 0; e_x = 0; e_y = 0; e_z = 0;
        end else begin
            e_valid = lk_valid; e_hit = 0; e_miss = 0; e_x = 0; e_y = 0; e_z = 0;
            if (lk_valid) begin
                vpn = longint'(lk_vaddr) / 1024;
                found = -1;
                for (int i = 0; i < NE; i++)
                    if (found < 0 && m_vld[i] &&
                        (vpn / (longint'(1) << m_gl[i])) == (m_tag[i] / (longint'(1) << m_gl[i])))
                        found = i;
                if (found >= 0) begin
                    e_hit = 1;
                    off = vpn % (longint'(1) << m_gl[found]);
                    idx = (off / (longint'(1) << m_pp[found])) %
                          (longint'(1) << (m_ex[found] + m_ey[found] + m_ez[found]));
                    e_x = int'((m_sx[found] + idx % (1 << m_ex[found])) % 64);
                    idx = idx / (1 << m_ex[found]);
                    e_y = int'((m_sy[found] + idx % (1 << m_ey[found])) % 64);
                    idx = idx / (1 << m_ey[found]);
                    e_z = int'((m_sz[found] + idx % (1 << m_ez[found])) % 64);
                end else begin
                    e_miss = 1;
                end
            end
            if (inval_all) begin
                for (int i = 0; i < NE; i++) m_vld[i] = 0;
                m_ptr = 0;
            end else if (fill_en) begin
                m_vld[m_ptr] = 1;
                m_tag[m_ptr] = longint'(fill_vpage);
                m_sx[m_ptr] = int'(fill_sx); m_sy[m_ptr] = int'(fill_sy); m_sz[m_ptr] = int'(fill_sz);
                m_ex[m_ptr] = int'(fill_ex); m_ey[m_ptr] = int'(fill_ey); m_ez[m_ptr] = int'(fill_ez);
                m_gl[m_ptr] = int'(fill_glen); m_pp[m_ptr] = int'(fill_ppn);
                m_ptr = (m_ptr + 1) % NE;
            end
        end
        armed = 1;
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            n_cmp++;
            if (res_valid !== e_valid || res_hit !== e_hit || res_miss !== e_miss ||
                int'(res_x) != e_x || int'(res_y) != e_y || int'(res_z) != e_z) begin
                n_bad++;
                $display("FAIL %s: got v%0b h%0b m%0b (%0d,%0d,%0d) expected v%0b h%0b m%0b (%0d,%0d,%0d)",
                         cur_req, res_valid, res_hit, res_miss, res_x, res_y, res_z,
                         e_valid, e_hit, e_miss, e_x, e_y, e_z);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 200000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            fill_en = 0; inval_all = 0; lk_valid = 0;
        end
    endtask

    task automatic set_fill(int tag, int sx, int sy, int sz, int ex, int ey, int ez, int gl, int pp);
        fill_vpage = VPN_W'(tag);
        fill_sx = COORD_W'(sx); fill_sy = COORD_W'(sy); fill_sz = COORD_W'(sz);
        fill_ex = EXT_W'(ex); fill_ey = EXT_W'(ey); fill_ez = EXT_W'(ez);
        fill_glen = GLEN_W'(gl); fill_ppn = PPN_W'(pp);
    endtask

    task automatic fill(int tag, int sx, int sy, int sz, int ex, int ey, int ez, int gl, int pp);
        @(negedge clk);
        inval_all = 0; lk_valid = 0; fill_en = 1;
        set_fill(tag, sx, sy, sz, ex, ey, ez, gl, pp);
    endtask

    task automatic look(int vpn);
        @(negedge clk);
        fill_en = 0; inval_all = 0; lk_valid = 1;
        lk_vaddr = {VPN_W'(vpn), PG_SHIFT'($urandom)};
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1;
        idle(2);
        look(16'h100);                     // R6: empty table misses
        cur_req = "R6";
        idle(1);

        // R3/R4/R5: cyclic interleave over 2x2x2 region, 16-page group
        cur_req = "R4";
        fill(16'h100, 2, 3, 4, 1, 1, 1, 4, 0);
        for (int p = 0; p < 16; p++) look(16'h100 + p);
        cur_req = "R3";
        look(16'h110); look(16'h0FF); look(16'h108);
        idle(1);

        // R4/R5: block interleave (4 pages per node) with coordinate wrap
        cur_req = "R5";
        fill(16'h200, 60, 1, 63, 2, 0, 1, 5, 2);
        for (int p = 0; p < 32; p++) look(16'h200 + p);
        idle(2);

        // R9: overlapping entry at a higher index loses
        cur_req = "R9";
        fill(16'h100, 10, 10, 10, 0, 0, 0, 6, 0);
        look(16'h105); look(16'h13F);
        idle(1);

        // R10: lookup in the fill cycle sees the old table
        cur_req = "R10";
        @(negedge clk);
        inval_all = 0; fill_en = 1; lk_valid = 1;
        set_fill(16'h280, 5, 6, 7, 0, 0, 0, 0, 0);
        lk_vaddr = {VPN_W'(16'h280), PG_SHIFT'(0)};
        look(16'h280);
        idle(1);

        // R7: round-robin wrap, ninth fill replaces entry 0
        cur_req = "R7";
        for (int i = 4; i < 9; i++) fill(16'h300 + i, i, 0, 0, 0, 0, 0, 0, 0);
        look(16'h100); look(16'h308);
        fill(16'h3FF, 33, 1, 2, 0, 0, 0, 0, 0);
        look(16'h3FF); look(16'h100); look(16'h200);
        idle(1);

        // R8: invalidate overrides a fill in the same cycle
        cur_req = "R8";
        @(negedge clk);
        lk_valid = 0; fill_en = 1; inval_all = 1;
        set_fill(16'h200, 1, 1, 1, 0, 0, 0, 0, 0);
        look(16'h200); look(16'h3FF);
        fill(16'h050, 7, 8, 9, 1, 1, 0, 2, 1);
        look(16'h051); look(16'h053);
        idle(1);

        // R2: random traffic with gaps
        cur_req = "R2";
        fill(16'h100, 2, 3, 4, 1, 1, 1, 4, 0);
        fill(16'h200, 60, 1, 63, 2, 0, 1, 5, 2);
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 4 == 0) idle(1);
            else case ($urandom % 4)
                0: look(16'h100 + int'($urandom % 20));
                1: look(16'h200 + int'($urandom % 40));
                2: look(16'h050 + int'($urandom % 6));
                default: look(int'($urandom % 4096));
            endcase
        end
        idle(3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule